// File: doc/BRIEF.md
# Flash Program/Erase Mode Entry Controller

This block sits between a simple register write bus and an embedded flash macro. It moves the flash between read mode and program/erase (P/E) mode. It does this only when software performs a guarded sequence. Each step of that sequence has its own safeguard:

- A 16-bit entry register must be written with a fixed key in its upper byte.
- A write-protect byte must arm the control register.
- The control register accepts a new code only through three writes: the value, its bitwise complement, then the value again.

A mode state machine follows the codes that software commits. It enforces the legal order of those codes. It also times the two mandatory settling waits with one shared cycle counter. While a wait runs, a busy output is high.

The mode state machine has these states:
- `M_READ`: read mode.
- `M_DIS_UP`: first wait on the way into P/E mode.
- `M_SPEED`: waiting for the speed code.
- `M_MS_UP`: second wait on the way into P/E mode.
- `M_PE`: P/E mode.
- `M_DIS_DN`: first wait on the way out.
- `M_LEAVE12`: waiting for the intermediate code on the way out.
- `M_LEAVE08`: waiting for the read code.
- `M_MS_DN`: second wait on the way out.
- `M_EXIT`: waiting for the entry bit to be cleared.

The transitions are:
- `M_READ` → `M_DIS_UP` on commit of 12h, with the entry bit set and low-speed operation off.
- `M_DIS_UP` → `M_SPEED` when the first wait ends.
- `M_SPEED` → `M_MS_UP` on commit of 82h or C2h.
- `M_MS_UP` → `M_PE` when the second wait ends.
- `M_PE` → `M_DIS_DN` on commit of 92h or D2h.
- `M_DIS_DN` → `M_LEAVE12` when the first wait ends.
- `M_LEAVE12` → `M_LEAVE08` on commit of 12h.
- `M_LEAVE08` → `M_MS_DN` on commit of 08h.
- `M_MS_DN` → `M_EXIT` when the second wait ends.
- `M_EXIT` → `M_READ` once the entry bit reads 0.

The unlock sequencer has four states:
- `U_IDLE`
- `U_ARMED`, after the protect key.
- `U_VAL`, after the value.
- `U_CPL`, after the complement.

A low-speed-operation input blocks every request that would start P/E entry.

Top module: `flash_mode_ctrl`

## Requirements
- R1: After reset the controller is in read mode:
  - `ctrl_q` = 08h and `entry_q` = 0000h.
  - `in_read_mode` = 1, `in_pe_mode` = 0.
  - `busy` = 0 and `unlock_fail` = 0.
- R2: The entry register is at address 0. A write takes effect only when `wr_data[15:8]` = AAh. In that case `wr_data[0]` = 1 sets the entry bit and `wr_data[0]` = 0 clears it. Writes with any other upper byte change nothing. The register reads back as 0000h or 0001h. Keyed writes are accepted only in the `M_READ` and `M_EXIT` states; in every other state they are ignored.
- R3: The control register (address 2, low byte) takes a new value only after this sequence, with no other write in between:
  1. A5h is written to the protect register (address 1).
  2. Three control writes follow: V, ~V, V.
- R4: Any of the following leaves `ctrl_q` unchanged and sets `unlock_fail`, which stays set until reset:
  - a control write without the protect key;
  - a wrong complement or wrong repeat;
  - any write to another address while a sequence is open.
- R5: P/E entry proceeds in this order:
  1. Set the entry bit.
  2. Commit 12h.
  3. A wait of T_DIS cycles.
  4. Commit 82h (high speed) or C2h (middle speed).
  5. A wait of T_MS cycles.
  6. `in_pe_mode` rises.
- R6: The return from P/E mode proceeds in this order:
  1. Commit 92h or D2h.
  2. A wait of T_DIS cycles.
  3. Commit 12h, then commit 08h.
  4. A wait of T_MS cycles.
  5. Write AA00h to the entry register.
  6. `entry_q` reads 0000h and `in_read_mode` returns one cycle later.
- R7: A completed unlock sequence whose code is not the legal next code for the current state is refused. `ctrl_q` is unchanged and `unlock_fail` is set.
- R8: `busy` is high for exactly T_DIS or T_MS cycles, starting in the cycle after the committing write. Control writes while `busy` is high are ignored. They do not change `ctrl_q`, the open unlock sequence or `unlock_fail`.
- R9: While `low_speed` is high, AA01h does not set the entry bit. A committed 12h in read mode is also refused; `ctrl_q` is unchanged and `unlock_fail` is set.
- R10: `in_pe_mode` is high only when the entry bit is 1 and `ctrl_q` is 82h or C2h. `in_read_mode` is high only when `ctrl_q` is 08h and the entry bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 2 | 0 entry register, 1 protect key, 2 control register |
| wr_data | input | 16 | Write data; byte registers use bits 7:0 |
| low_speed | input | 1 | Low-speed operation active; blocks P/E entry |
| entry_q | output | 16 | Entry register readback (0000h or 0001h) |
| ctrl_q | output | 8 | Current control register code |
| in_read_mode | output | 1 | Read mode reached |
| in_pe_mode | output | 1 | P/E mode reached |
| busy | output | 1 | Transition wait running |
| unlock_fail | output | 1 | Sticky protected-write failure flag |

## Verification
A wrong internal state shows at the ports within one cycle. An unlock sequencer stuck in the wrong state would make the next control write either commit or fail unexpectedly. That is visible on `ctrl_q` or `unlock_fail` at the following clock edge. A mode state machine in the wrong state appears as a wrong `busy` length, as a refused legal code (the flag rises) or as a mode output that disagrees with `ctrl_q` and `entry_q`. The bench counts busy cycles exactly and compares the codes after every commit, so an off-by-one wait or a skipped state is caught at the end of the affected step.

// File: rtl/fmc_pkg.sv
package fmc_pkg;

    typedef enum logic [3:0] {
        M_READ, M_DIS_UP, M_SPEED, M_MS_UP, M_PE,
        M_DIS_DN, M_LEAVE12, M_LEAVE08, M_MS_DN, M_EXIT
    } mode_e;

    typedef enum logic [1:0] {
        U_IDLE, U_ARMED, U_VAL, U_CPL
    } unl_e;

    localparam logic [1:0] A_ENTRY = 2'd0;
    localparam logic [1:0] A_KEY   = 2'd1;
    localparam logic [1:0] A_CTRL  = 2'd2;

    localparam logic [7:0] ENTRY_KEY = 8'hAA;
    localparam logic [7:0] PROT_KEY  = 8'hA5;
    localparam logic [7:0] C_READ    = 8'h08;
    localparam logic [7:0] C_STEP    = 8'h12;
    localparam logic [7:0] C_PE_HI   = 8'h82;
    localparam logic [7:0] C_PE_MID  = 8'hC2;
    localparam logic [7:0] C_LV_HI   = 8'h92;
    localparam logic [7:0] C_LV_MID  = 8'hD2;

endpackage

// File: rtl/fmc_wait_timer.sv
module fmc_wait_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] len,
    output logic         last,
    output logic         active
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= len;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    always_comb begin
        last   = (cnt == W'(1));
        active = (cnt != '0);
    end

    // R8: a wait is never requested with zero length or while one runs
    a_r8_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (len != '0));
    a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !active);

endmodule

// File: rtl/fmc_unlock.sv
module fmc_unlock
    import fmc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_addr,
    input  logic [7:0]  wr_byte,
    input  logic        busy,
    output logic        cand_valid,
    output logic [7:0]  cand_val,
    output logic        seq_fail
);

    unl_e       st, st_nx;
    logic [7:0] val_q, val_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= U_IDLE;
            val_q <= '0;
        end else begin
            st    <= st_nx;
            val_q <= val_nx;
        end
    end

    always_comb begin
        st_nx      = st;
        val_nx     = val_q;
        cand_valid = 1'b0;
        seq_fail   = 1'b0;
        if (wr_en) begin
            unique case (wr_addr)
                A_KEY: begin
                    if (st == U_IDLE) begin
                        if (wr_byte == PROT_KEY) st_nx = U_ARMED;
                    end else begin
                        seq_fail = 1'b1;
                        st_nx    = U_IDLE;
                    end
                end
                A_CTRL: begin
                    if (!busy) begin
                        unique case (st)
                            U_IDLE: seq_fail = 1'b1;
                            U_ARMED: begin
                                val_nx = wr_byte;
                                st_nx  = U_VAL;
                            end
                            U_VAL: begin
                                if (wr_byte == ~val_q) begin
                                    st_nx = U_CPL;
                                end else begin
                                    seq_fail = 1'b1;
                                    st_nx    = U_IDLE;
                                end
                            end
                            U_CPL: begin
                                if (wr_byte == val_q) cand_valid = 1'b1;
                                else                  seq_fail   = 1'b1;
                                st_nx = U_IDLE;
                            end
                            default: st_nx = U_IDLE;
                        endcase
                    end
                end
                default: begin
                    if (st != U_IDLE) begin
                        seq_fail = 1'b1;
                        st_nx    = U_IDLE;
                    end
                end
            endcase
        end
    end

    assign cand_val = val_q;

    // R4: a write cannot both complete and break a sequence
    a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(cand_valid && seq_fail));
    // R3: a completed sequence closes the unlock window
    a_r3_close_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
        cand_valid |=> (st == U_IDLE));
    // R8: control writes during a wait leave the sequence untouched
    a_r8_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en && wr_addr == A_CTRL) |=> ($stable(st) && $stable(val_q)));

endmodule

// File: rtl/fmc_mode_fsm.sv
module fmc_mode_fsm
    import fmc_pkg::*;
#(
    parameter int T_DIS = 6,
    parameter int T_MS  = 9,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   wr_addr,
    input  logic [15:0]  wr_data,
    input  logic         low_speed,
    input  logic         cand_valid,
    input  logic [7:0]   cand_val,
    input  logic         tmr_last,
    output logic         tmr_start,
    output logic [W-1:0] tmr_len,
    output logic [7:0]   ctrl_q,
    output logic         entry_bit,
    output logic         reject,
    output logic         busy,
    output logic         in_pe,
    output logic         in_read
);

    mode_e st, st_nx;
    logic  accept;
    logic  ent_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= M_READ;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx     = st;
        accept    = 1'b0;
        tmr_start = 1'b0;
        tmr_len   = W'(T_DIS);
        unique case (st)
            M_READ: begin
                if (cand_valid && cand_val == C_STEP && entry_bit && !low_speed) begin
                    accept = 1'b1; tmr_start = 1'b1; tmr_len = W'(T_DIS);
                    st_nx  = M_DIS_UP;
                end
            end
            M_DIS_UP:  if (tmr_last) st_nx = M_SPEED;
            M_SPEED: begin
                if (cand_valid && (cand_val == C_PE_HI || cand_val == C_PE_MID)) begin
                    accept = 1'b1; tmr_start = 1'b1; tmr_len = W'(T_MS);
                    st_nx  = M_MS_UP;
                end
            end
            M_MS_UP:   if (tmr_last) st_nx = M_PE;
            M_PE: begin
                if (cand_valid && (cand_val == C_LV_HI || cand_val == C_LV_MID)) begin
                    accept = 1'b1; tmr_start = 1'b1; tmr_len = W'(T_DIS);
                    st_nx  = M_DIS_DN;
                end
            end
            M_DIS_DN:  if (tmr_last) st_nx = M_LEAVE12;
            M_LEAVE12: begin
                if (cand_valid && cand_val == C_STEP) begin
                    accept = 1'b1;
                    st_nx  = M_LEAVE08;
                end
            end
            M_LEAVE08: begin
                if (cand_valid && cand_val == C_READ) begin
                    accept = 1'b1; tmr_start = 1'b1; tmr_len = W'(T_MS);
                    st_nx  = M_MS_DN;
                end
            end
            M_MS_DN:   if (tmr_last) st_nx = M_EXIT;
            M_EXIT:    if (!entry_bit) st_nx = M_READ;
            default:   st_nx = M_READ;
        endcase
    end

    assign ent_wr = wr_en && (wr_addr == A_ENTRY) && (wr_data[15:8] == ENTRY_KEY)
                    && ((st == M_READ) || (st == M_EXIT));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q    <= C_READ;
            entry_bit <= 1'b0;
        end else begin
            if (accept) ctrl_q <= cand_val;
            if (ent_wr) begin
                if (!wr_data[0])     entry_bit <= 1'b0;
                else if (!low_speed) entry_bit <= 1'b1;
            end
        end
    end

    always_comb begin
        reject  = cand_valid && !accept;
        busy    = (st == M_DIS_UP) || (st == M_MS_UP) || (st == M_DIS_DN) || (st == M_MS_DN);
        in_pe   = (st == M_PE);
        in_read = (st == M_READ) && !entry_bit;
    end

    // R2: unkeyed entry writes change nothing
    a_r2_bad_key: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_ENTRY && wr_data[15:8] != ENTRY_KEY) |=> $stable(entry_bit));
    // R2: entry register is locked outside read and exit states
    a_r2_entry_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_ENTRY && st != M_READ && st != M_EXIT) |=> $stable(entry_bit));
    // R9: low-speed operation keeps the block in read state
    a_r9_low_speed_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st == M_READ && low_speed) |=> (st == M_READ));
    // R10: mode outputs agree with the registers
    a_r10_pe_cond: assert property (@(posedge clk) disable iff (!rst_n)
        in_pe |-> (entry_bit && (ctrl_q == C_PE_HI || ctrl_q == C_PE_MID)));
    a_r10_read_cond: assert property (@(posedge clk) disable iff (!rst_n)
        in_read |-> (ctrl_q == C_READ && !entry_bit));
    // R7: a refused code leaves the control register as it was
    a_r7_refused_stable: assert property (@(posedge clk) disable iff (!rst_n)
        reject |=> $stable(ctrl_q));

endmodule

// File: rtl/flash_mode_ctrl.sv
module flash_mode_ctrl
    import fmc_pkg::*;
#(
    parameter int T_DIS = 6,
    parameter int T_MS  = 9
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_addr,
    input  logic [15:0] wr_data,
    input  logic        low_speed,
    output logic [15:0] entry_q,
    output logic [7:0]  ctrl_q,
    output logic        in_read_mode,
    output logic        in_pe_mode,
    output logic        busy,
    output logic        unlock_fail
);

    localparam int TMAX = (T_DIS > T_MS) ? T_DIS : T_MS;
    localparam int W    = $clog2(TMAX + 1);

    logic         cand_valid, seq_fail, reject;
    logic [7:0]   cand_val;
    logic         tmr_start, tmr_last, tmr_active;
    logic [W-1:0] tmr_len;
    logic         entry_bit;
    logic         fail_q;

    fmc_unlock i_unlock (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_byte    (wr_data[7:0]),
        .busy       (busy),
        .cand_valid (cand_valid),
        .cand_val   (cand_val),
        .seq_fail   (seq_fail)
    );

    fmc_mode_fsm #(.T_DIS(T_DIS), .T_MS(T_MS), .W(W)) i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .low_speed  (low_speed),
        .cand_valid (cand_valid),
        .cand_val   (cand_val),
        .tmr_last   (tmr_last),
        .tmr_start  (tmr_start),
        .tmr_len    (tmr_len),
        .ctrl_q     (ctrl_q),
        .entry_bit  (entry_bit),
        .reject     (reject),
        .busy       (busy),
        .in_pe      (in_pe_mode),
        .in_read    (in_read_mode)
    );

    fmc_wait_timer #(.W(W)) i_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (tmr_start),
        .len    (tmr_len),
        .last   (tmr_last),
        .active (tmr_active)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 fail_q <= 1'b0;
        else if (seq_fail || reject) fail_q <= 1'b1;
    end

    assign unlock_fail = fail_q;
    assign entry_q     = {15'b0, entry_bit};

    // R4: the failure flag is sticky
    a_r4_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        unlock_fail |=> unlock_fail);
    // R8: busy is only reported while the wait counter runs
    a_r8_busy_timer: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> tmr_active);

endmodule

// File: tb/test_flash_mode_ctrl.sv
module test_flash_mode_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int TD = 6;
    localparam int TM = 9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        low_speed = 1'b0;
    logic [15:0] entry_q;
    logic [7:0]  ctrl_q;
    logic        in_read_mode, in_pe_mode, busy, unlock_fail;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_mode_ctrl #(.T_DIS(TD), .T_MS(TM)) i_flash_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .low_speed(low_speed), .entry_q(entry_q),
        .ctrl_q(ctrl_q), .in_read_mode(in_read_mode), .in_pe_mode(in_pe_mode),
        .busy(busy), .unlock_fail(unlock_fail)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        low_speed = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic ctrl_seq(input logic [7:0] v);
        wr(2'd1, 16'h00A5);
        wr(2'd2, {8'h00, v});
        wr(2'd2, {8'h00, ~v});
        wr(2'd2, {8'h00, v});
    endtask

    task automatic count_busy(input string req, input int exp);
        int n = 0;
        while (busy && n < 1000) begin
            n++;
            @(negedge clk);
        end
        chk(req, 16'(n), 16'(exp));
    endtask

    task automatic t_reset();
        chk("R1 ctrl", {8'h0, ctrl_q}, 16'h0008);
        chk("R1 entry", entry_q, 16'h0000);
        chk("R1 read", {15'b0, in_read_mode}, 16'd1);
        chk("R1 pe", {15'b0, in_pe_mode}, 16'd0);
        chk("R1 busy", {15'b0, busy}, 16'd0);
        chk("R1 fail", {15'b0, unlock_fail}, 16'd0);
    endtask

    task automatic t_entry_key();
        wr(2'd0, 16'h5501);
        chk("R2 bad key ignored", entry_q, 16'h0000);
        wr(2'd0, 16'hAA01);
        chk("R2 set", entry_q, 16'h0001);
        chk("R10 read off when entry set", {15'b0, in_read_mode}, 16'd0);
        wr(2'd0, 16'hAA00);
        chk("R2 clear", entry_q, 16'h0000);
    endtask

    task automatic t_enter(input logic [7:0] spd);
        wr(2'd0, 16'hAA01);
        ctrl_seq(8'h12);
        chk("R3 commit 12h", {8'h0, ctrl_q}, 16'h0012);
        count_busy("R8 tDIS length", TD);
        ctrl_seq(spd);
        chk("R5 speed code", {8'h0, ctrl_q}, {8'h0, spd});
        chk("R5 not yet pe", {15'b0, in_pe_mode}, 16'd0);
        count_busy("R8 tMS length", TM);
        chk("R5 pe reached", {15'b0, in_pe_mode}, 16'd1);
        chk("R10 pe entry bit", entry_q, 16'h0001);
    endtask

    task automatic t_exit(input logic [7:0] lv);
        wr(2'd0, 16'hAA00);
        chk("R2 locked in pe", entry_q, 16'h0001);
        chk("R2 pe kept", {15'b0, in_pe_mode}, 16'd1);
        ctrl_seq(lv);
        chk("R6 leave code", {8'h0, ctrl_q}, {8'h0, lv});
        count_busy("R6 tDIS length", TD);
        ctrl_seq(8'h12);
        chk("R6 step 12h", {8'h0, ctrl_q}, 16'h0012);
        ctrl_seq(8'h08);
        chk("R6 step 08h", {8'h0, ctrl_q}, 16'h0008);
        count_busy("R6 tMS length", TM);
        chk("R6 not read before clear", {15'b0, in_read_mode}, 16'd0);
        wr(2'd0, 16'hAA00);
        chk("R6 entry cleared", entry_q, 16'h0000);
        @(negedge clk);
        chk("R6 read mode", {15'b0, in_read_mode}, 16'd1);
        chk("R6 no fail", {15'b0, unlock_fail}, 16'd0);
    endtask

    task automatic t_busy_ignore();
        wr(2'd0, 16'hAA01);
        ctrl_seq(8'h12);
        wr(2'd1, 16'h00A5);
        wr(2'd2, 16'h00C2);
        chk("R8 ctrl kept during busy", {8'h0, ctrl_q}, 16'h0012);
        chk("R8 no fail during busy", {15'b0, unlock_fail}, 16'd0);
        while (busy) @(negedge clk);
        wr(2'd2, 16'h00C2);
        wr(2'd2, 16'h003D);
        wr(2'd2, 16'h00C2);
        chk("R8 key survived busy", {8'h0, ctrl_q}, 16'h00C2);
        count_busy("R5 tMS middle", TM);
        chk("R5 pe middle", {15'b0, in_pe_mode}, 16'd1);
        chk("R8 fail clear", {15'b0, unlock_fail}, 16'd0);
    endtask

    task automatic t_fail_cases();
        do_reset();
        wr(2'd2, 16'h0012);
        chk("R4 no key fail", {15'b0, unlock_fail}, 16'd1);
        chk("R4 no key ctrl", {8'h0, ctrl_q}, 16'h0008);
        do_reset();
        wr(2'd0, 16'hAA01);
        wr(2'd1, 16'h00A5);
        wr(2'd2, 16'h0012);
        wr(2'd2, 16'h00EE);
        wr(2'd2, 16'h0012);
        chk("R4 bad complement ctrl", {8'h0, ctrl_q}, 16'h0008);
        chk("R4 bad complement fail", {15'b0, unlock_fail}, 16'd1);
        do_reset();
        wr(2'd1, 16'h00A5);
        wr(2'd2, 16'h0012);
        wr(2'd0, 16'h5500);
        wr(2'd2, 16'h00ED);
        wr(2'd2, 16'h0012);
        chk("R4 interrupted ctrl", {8'h0, ctrl_q}, 16'h0008);
        chk("R4 interrupted fail", {15'b0, unlock_fail}, 16'd1);
        repeat (3) @(negedge clk);
        chk("R4 sticky", {15'b0, unlock_fail}, 16'd1);
    endtask

    task automatic t_order();
        do_reset();
        wr(2'd0, 16'hAA01);
        ctrl_seq(8'h82);
        chk("R7 out of order ctrl", {8'h0, ctrl_q}, 16'h0008);
        chk("R7 out of order fail", {15'b0, unlock_fail}, 16'd1);
        chk("R7 no pe", {15'b0, in_pe_mode}, 16'd0);
    endtask

    task automatic t_low_speed();
        do_reset();
        low_speed = 1'b1;
        wr(2'd0, 16'hAA01);
        chk("R9 entry refused", entry_q, 16'h0000);
        low_speed = 1'b0;
        wr(2'd0, 16'hAA01);
        chk("R9 entry after low speed", entry_q, 16'h0001);
        low_speed = 1'b1;
        ctrl_seq(8'h12);
        chk("R9 12h refused", {8'h0, ctrl_q}, 16'h0008);
        chk("R9 fail set", {15'b0, unlock_fail}, 16'd1);
        chk("R9 no busy", {15'b0, busy}, 16'd0);
        low_speed = 1'b0;
    endtask

    initial begin
        do_reset();
        t_reset();
        t_entry_key();
        t_enter(8'h82);
        t_exit(8'h92);
        t_busy_ignore();
        t_exit(8'hD2);
        t_fail_cases();
        t_order();
        t_low_speed();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule